// File: doc/BRIEF.md
# LCD Frame and Blink Timebase

This block turns one LCD input clock into the timing enables that a segment LCD driver needs. A power-of-two prescaler feeds a divider of ratio 16 plus a 4-bit field. The result is a one-cycle divided-clock enable, which also serves as the per-phase tick. A phase sequencer counts these ticks across the common lines of the selected duty. It marks the start of each frame. A blink stage divides the same enable by a further power of two and drives a blink level that toggles at each blink event.

The total ratio from the input clock to the divided enable is 2^ps_cfg × (16 + div_cfg). For example, ps 7 with div 3 gives 2432, and ps 9 with div 3 gives 9728. The frame rate is the divided rate divided by the number of commons. All settings are held in shadow registers. They are reloaded only on the clock edge that ends a divided-clock period, so a change never cuts a period short or stretches it.

Top module: `lcd_timebase`

## Requirements
- R1: While rst is high, div_tick, frame_tick, blink_tick and blink_out are 0 and phase_idx is 0. On the edges where rst is high, the shadow registers take the configuration inputs.
- R2: After rst falls, div_tick is first high in the cycle that follows the R-th rising edge with rst low, where R = 2^ps_cfg × (16 + div_cfg).
- R3: div_tick is high for exactly one cycle, and successive pulses are R cycles apart.
- R4: Configuration inputs are sampled on the edge that raises div_tick. The period that starts at that edge uses the new values. A change made between two pulses does not alter the period in progress.
- R5: phase_idx steps by one on each div_tick and returns to 0 after the last common. The number of commons is set by duty_cfg: code 0 gives 1 (static), 1 gives 2, 2 gives 3, 3 gives 4, and 4 to 7 give 8.
- R6: frame_tick is a one-cycle pulse, high together with the div_tick that returns phase_idx to 0, that is on every N-th divided tick.
- R7: blink_tick is high together with every 2^(blink_cfg+3)-th div_tick counted from reset.
- R8: blink_out toggles exactly in the cycles where blink_tick is high and holds its value otherwise. It starts at 0.
- R9: frame_tick and blink_tick are never high without div_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD input clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_cfg | input | 4 | Prescaler exponent, division by 2^ps_cfg |
| div_cfg | input | 4 | Divider offset, division by 16 + div_cfg |
| blink_cfg | input | 3 | Blink exponent, division by 2^(blink_cfg+3) |
| duty_cfg | input | 3 | Duty code selecting the number of commons |
| div_tick | output | 1 | Divided-clock (phase) enable pulse |
| frame_tick | output | 1 | Start-of-frame pulse |
| phase_idx | output | 3 | Index of the active common phase |
| blink_tick | output | 1 | Blink event pulse |
| blink_out | output | 1 | Blink level |

## Verification
The assertions assume that the configuration inputs are driven synchronously to clk, and that the ratio is always at least 16 cycles, so a divided pulse can never follow another at once. The stimulus changes the configuration only at negative clock edges. Random runs draw small prescaler and blink exponents so that each run stays within a few thousand cycles. The duty code is left unchanged between resets, and the blink code is changed only while reset is asserted, so the expected frame and blink counts stay aligned to reset.

// File: rtl/lcd_timebase_pkg.sv
package lcd_timebase_pkg;
  localparam int PS_W     = 4;
  localparam int DIV_W    = 4;
  localparam int BLK_W    = 3;
  localparam int DUTY_W   = 3;
  localparam int DIV_BASE = 16;
  localparam int MAX_COM  = 8;
  localparam int PH_W     = $clog2(MAX_COM);

  typedef struct packed {
    logic [PS_W-1:0]   ps;
    logic [DIV_W-1:0]  dv;
    logic [BLK_W-1:0]  bk;
    logic [DUTY_W-1:0] dt;
  } tb_cfg_t;

  // last phase index for a duty code
  function automatic logic [PH_W-1:0] last_phase(input logic [DUTY_W-1:0] code);
    case (code)
      3'd0:    last_phase = PH_W'(0);
      3'd1:    last_phase = PH_W'(1);
      3'd2:    last_phase = PH_W'(2);
      3'd3:    last_phase = PH_W'(3);
      default: last_phase = PH_W'(MAX_COM - 1);
    endcase
  endfunction
endpackage

// File: rtl/lcd_timebase_shadow.sv
module lcd_timebase_shadow
  import lcd_timebase_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  tb_cfg_t cfg_in,
  output tb_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst || load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/lcd_timebase_ratio.sv
module lcd_timebase_ratio #(
  parameter int PS_W     = 4,
  parameter int DIV_W    = 4,
  parameter int DIV_BASE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PS_W-1:0]  ps,
  input  logic [DIV_W-1:0] dv,
  output logic             wrap
);
  localparam int PRE_W = (2 ** PS_W) - 1;
  localparam int DC_W  = $clog2(DIV_BASE + (2 ** DIV_W));

  logic [PRE_W-1:0] pre_cnt;
  logic [DC_W-1:0]  div_cnt;
  logic [PRE_W-1:0] pre_mask;
  logic             pre_last;
  logic             div_last;

  assign pre_mask = ~({PRE_W{1'b1}} << ps);
  assign pre_last = (pre_cnt == pre_mask);
  assign div_last = (div_cnt == (DC_W'(DIV_BASE - 1) + DC_W'(dv)));
  assign wrap     = pre_last && div_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_last) begin
      pre_cnt <= '0;
      div_cnt <= div_last ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_timebase_phase.sv
module lcd_timebase_phase #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [PH_W-1:0] last_idx,
  output logic [PH_W-1:0] phase_q,
  output logic            frame_q
);
  logic at_end;
  assign at_end = (phase_q >= last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= step && at_end;
      if (step) phase_q <= at_end ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_timebase_blink.sv
module lcd_timebase_blink #(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [BLK_W-1:0] sel,
  output logic             tick_q,
  output logic             level_q
);
  localparam int BC_W = (2 ** BLK_W) - 1 + 3;

  logic [BC_W-1:0] cnt;
  logic [BC_W-1:0] mask;
  logic            term;

  assign mask = ~({BC_W{1'b1}} << (32'(sel) + 32'd3));
  assign term = ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tick_q  <= 1'b0;
      level_q <= 1'b0;
    end else begin
      tick_q <= step && term;
      if (step) begin
        cnt <= term ? '0 : cnt + 1'b1;
        if (term) level_q <= ~level_q;
      end
    end
  end
endmodule

// File: rtl/lcd_timebase.sv
module lcd_timebase
  import lcd_timebase_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PS_W-1:0]   ps_cfg,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [BLK_W-1:0]  blink_cfg,
  input  logic [DUTY_W-1:0] duty_cfg,
  output logic              div_tick,
  output logic              frame_tick,
  output logic [PH_W-1:0]   phase_idx,
  output logic              blink_tick,
  output logic              blink_out
);
  tb_cfg_t cfg_in;
  tb_cfg_t cfg_act;
  logic    wrap;

  assign cfg_in = '{ps: ps_cfg, dv: div_cfg, bk: blink_cfg, dt: duty_cfg};

  lcd_timebase_shadow u_shadow (
    .clk    (clk),
    .rst    (rst),
    .load   (wrap),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_act)
  );

  lcd_timebase_ratio #(
    .PS_W(PS_W), .DIV_W(DIV_W), .DIV_BASE(DIV_BASE)
  ) u_ratio (
    .clk  (clk),
    .rst  (rst),
    .ps   (cfg_act.ps),
    .dv   (cfg_act.dv),
    .wrap (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) div_tick <= 1'b0;
    else     div_tick <= wrap;
  end

  lcd_timebase_phase #(.PH_W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .step     (wrap),
    .last_idx (last_phase(cfg_act.dt)),
    .phase_q  (phase_idx),
    .frame_q  (frame_tick)
  );

  lcd_timebase_blink #(.BLK_W(BLK_W)) u_blink (
    .clk     (clk),
    .rst     (rst),
    .step    (wrap),
    .sel     (cfg_act.bk),
    .tick_q  (blink_tick),
    .level_q (blink_out)
  );
endmodule

// File: rtl/lcd_timebase_chk.sv
module lcd_timebase_chk #(
  parameter int PH_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            div_tick,
  input logic            frame_tick,
  input logic [PH_W-1:0] phase_idx,
  input logic            blink_tick,
  input logic            blink_out
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!div_tick && !frame_tick && !blink_tick && !blink_out && phase_idx == '0));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> !div_tick);

  p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !div_tick |-> $stable(phase_idx));

  p_frame_phase_r6: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> (phase_idx == '0));

  p_blink_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    blink_tick |-> (blink_out != $past(blink_out)));

  p_blink_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !blink_tick |-> $stable(blink_out));

  p_frame_with_div_r9: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> div_tick);

  p_blink_with_div_r9: assert property (@(posedge clk) disable iff (rst)
    blink_tick |-> div_tick);
endmodule

bind lcd_timebase lcd_timebase_chk #(.PH_W(lcd_timebase_pkg::PH_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .div_tick   (div_tick),
  .frame_tick (frame_tick),
  .phase_idx  (phase_idx),
  .blink_tick (blink_tick),
  .blink_out  (blink_out)
);

// File: tb/lcd_timebase_tb_top.sv
module lcd_timebase_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ps_cfg = '0;
  logic [3:0] div_cfg = '0;
  logic [2:0] blink_cfg = '0;
  logic [2:0] duty_cfg = '0;
  logic       div_tick, frame_tick, blink_tick, blink_out;
  logic [2:0] phase_idx;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  lcd_timebase dut_i (
    .clk(clk), .rst(rst), .ps_cfg(ps_cfg), .div_cfg(div_cfg),
    .blink_cfg(blink_cfg), .duty_cfg(duty_cfg), .div_tick(div_tick),
    .frame_tick(frame_tick), .phase_idx(phase_idx),
    .blink_tick(blink_tick), .blink_out(blink_out)
  );

  function automatic int ratio(int ps, int dv);
    return (1 << ps) * (16 + dv);
  endfunction

  function automatic int ncom(int dt);
    case (dt)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      summary();
    end
  end

  // waits for the next div_tick; reports the cycle count and stray pulses (R9)
  task automatic wait_tick(output int n, output bit stray);
    n = 0;
    stray = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (!div_tick && (frame_tick || blink_tick)) stray = 1'b1;
    end while (!div_tick && n < 5000);
  endtask

  task automatic do_reset(int ps, int dv, int bk, int dt);
    @(negedge clk);
    ps_cfg = 4'(ps); div_cfg = 4'(dv); blink_cfg = 3'(bk); duty_cfg = 3'(dt);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk(!div_tick && !frame_tick && !blink_tick && !blink_out && phase_idx == 0,
        "R1 reset state", {div_tick, frame_tick, blink_tick, blink_out, phase_idx}, 0);
    rst = 1'b0;
  endtask

  // reset with a configuration, then follow a number of divided ticks
  task automatic run(int ps, int dv, int bk, int dt, int ticks);
    int  n;
    bit  stray;
    int  k = 0;
    bit  lvl = 1'b0;
    int  nb = 1 << (bk + 3);
    int  nc = ncom(dt);
    do_reset(ps, dv, bk, dt);
    for (int i = 0; i < ticks; i++) begin
      wait_tick(n, stray);
      k++;
      if (i == 0) chk(n == ratio(ps, dv), "R2 first tick delay", n, ratio(ps, dv));
      else        chk(n == ratio(ps, dv), "R3 tick period", n, ratio(ps, dv));
      chk(!stray, "R9 stray frame or blink pulse", int'(stray), 0);
      chk(phase_idx == 3'((k % nc)), "R5 phase index", phase_idx, k % nc);
      chk(frame_tick == (k % nc == 0), "R6 frame tick", frame_tick, int'(k % nc == 0));
      chk(blink_tick == (k % nb == 0), "R7 blink tick", blink_tick, int'(k % nb == 0));
      if (k % nb == 0) lvl = ~lvl;
      chk(blink_out == lvl, "R8 blink level", blink_out, lvl);
    end
  endtask

  // R4: change ratio settings between ticks
  task automatic run_change(int ps_a, int dv_a, int ps_b, int dv_b, bit mid);
    int n;
    bit stray;
    do_reset(ps_a, dv_a, 0, 3);
    wait_tick(n, stray);
    wait_tick(n, stray);
    if (mid) begin
      repeat (5) @(negedge clk);
    end
    ps_cfg = 4'(ps_b); div_cfg = 4'(dv_b);
    wait_tick(n, stray);
    if (mid) n += 5;
    chk(n == ratio(ps_a, dv_a), "R4 period in progress keeps old ratio", n, ratio(ps_a, dv_a));
    wait_tick(n, stray);
    chk(n == ratio(ps_b, dv_b), "R4 next period uses new ratio", n, ratio(ps_b, dv_b));
    wait_tick(n, stray);
    chk(n == ratio(ps_b, dv_b), "R4 new ratio persists", n, ratio(ps_b, dv_b));
  endtask

  initial begin
    void'($urandom(32'd24681));
    // directed corners
    run(0, 0, 0, 0, 17);      // smallest ratio, static duty
    run(0, 15, 0, 1, 17);     // largest divider offset
    run(2, 3, 1, 2, 33);      // 1/3 duty, blink by 16
    run(1, 0, 2, 3, 65);      // 1/4 duty, blink by 32
    run(0, 7, 0, 4, 17);      // 8 commons
    run(0, 2, 0, 6, 17);      // upper duty code behaves as 8 commons
    run(3, 1, 0, 3, 9);       // larger prescaler
    run_change(1, 3, 0, 10, 1'b0);
    run_change(0, 4, 2, 1, 1'b1);
    run_change(2, 0, 0, 0, 1'b1);
    // random configurations
    for (int r = 0; r < 24; r++) begin
      int ps = $urandom_range(0, 2);
      int dv = $urandom_range(0, 15);
      int bk = $urandom_range(0, 1);
      int dt = $urandom_range(0, 7);
      run(ps, dv, bk, dt, (1 << (bk + 3)) + 1);
    end
    summary();
  end
endmodule